// File: doc/BRIEF.md
# Serial/Parallel Tone Command Receiver

This block takes tone-selection commands from a host controller and holds the result as a registered tone-selection word. A downstream synthesiser reads that word to produce one or two tones. The word has a row index, a column index and an enable for each. The host uses one of two modes. In serial mode it shifts 5-bit codes, least significant bit first, on a slow external clock. In parallel mode it drives a 4-bit bus. A mode-select pin chooses between them, and an active-low chip enable gates both.

All external pins are brought into the system clock domain through flop synchronisers. Serial bits are taken on the falling edges of the synchronised host clock. The code map is not sequential. It yields dual tones, single row or column tones, or an explicit "off" command. Codes that are not defined are dropped and do not disturb the tone currently requested.

Top module: `dtmf_cmd_rx`

## Requirements
- R1: In serial mode with chip enable low, the block takes one data bit on each falling edge of the host clock. The first bit is the code's bit 0, and a command is decoded only after the fifth bit.
- R2: Row index 0..3 means 697/770/852/941 Hz, and column index 0..3 means 1209/1336/1477/1633 Hz. Codes 1..9 give row (c-1)/3 and column (c-1)%3. Codes 10, 11 and 12 give row 3 with columns 1, 0 and 2. Code 0 gives row 3, column 3. Codes 13..15 give row c-13, column 3. Every code 0..15 sets both enables.
- R3: Codes 16..19 set only the row enable, with row index c-16. Codes 20..23 set only the column enable, with column index c-20. The unused index reads 0.
- R4: Code 31 is a valid command that clears both enables and both indices.
- R5: Codes 24..30 are ignored: the outputs keep their previous value and no pulse is raised.
- R6: While chip enable is high, all outputs are 0 and host clock edges have no effect. If chip enable rises in the middle of a word, the partial bits are discarded.
- R7: `cmd_valid_o` is a one-cycle pulse for each accepted command, and the outputs take the new value in the same cycle. The outputs change at no other time except when they are cleared by chip enable.
- R8: In parallel mode (mode pin high) with chip enable low, bus value b is taken as code b, a dual tone. The bus is taken when the mode is entered and whenever its value changes. A stable bus and the serial pins do nothing.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_i | input | 1 | Chip enable, active low |
| mode_par_i | input | 1 | 1 = parallel bus mode, 0 = serial mode |
| sclk_i | input | 1 | Host serial clock |
| sdata_i | input | 1 | Host serial data |
| pdata_i | input | PAR_W | Parallel code bus |
| row_o | output | 2 | Row tone index |
| col_o | output | 2 | Column tone index |
| row_en_o | output | 1 | Row tone requested |
| col_en_o | output | 1 | Column tone requested |
| cmd_valid_o | output | 1 | Pulse on each accepted command |

## Verification
The serial path is swept over all 32 codes in ascending order with chip enable held low. This separates the dual, single-row, single-column, off and unused groups. Each unused code follows a valid one, so an unused code that leaks through shows up as a changed output. A code whose bit order is reversed in a different code (6 against 12) exposes a shift-direction error. A word broken off by chip enable and then followed by a complete word tells a reset bit counter apart from a stale one. The parallel bus is stepped through all 16 values, then held stable while the serial clock toggles, to show that commits follow bus changes only.

// File: rtl/dtmf_cmd_pkg.sv
package dtmf_cmd_pkg;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic       row_en;
    logic       col_en;
    logic [1:0] row;
    logic [1:0] col;
  } tone_cmd_t;

  localparam tone_cmd_t TONE_OFF = '0;
endpackage

// File: rtl/dtmf_sync.sv
module dtmf_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dtmf_ser_shift.sv
module dtmf_ser_shift #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fall_i,
  input  logic              bit_i,
  output logic [CODE_W-1:0] word_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (fall_i) begin
        // LSB arrives first: shift toward bit 0
        sh_q <= {bit_i, sh_q[CODE_W-1:1]};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o = sh_q;

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_done_fifth_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(fall_i) && $past(cnt_q) == LAST && !$past(clr_i)));
  p_clr_discards_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (cnt_q == '0 && !done_o));
endmodule

// File: rtl/dtmf_decode.sv
module dtmf_decode
  import dtmf_cmd_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output tone_cmd_t         cmd_o
);
  logic [4:0] c;
  logic [1:0] r;

  always_comb begin
    c       = code_i;
    valid_o = 1'b1;
    cmd_o   = TONE_OFF;
    r       = (c >= 5'd7) ? 2'd2 : (c >= 5'd4) ? 2'd1 : 2'd0;
    if (!c[4]) begin
      cmd_o.row_en = 1'b1;
      cmd_o.col_en = 1'b1;
      if (c == 5'd0) begin
        cmd_o.row = 2'd3;
        cmd_o.col = 2'd3;
      end else if (c <= 5'd9) begin
        // keypad digits: three per row
        cmd_o.row = r;
        cmd_o.col = 2'(c - 5'd1 - 5'(3 * r));
      end else if (c == 5'd10) begin
        cmd_o.row = 2'd3;
        cmd_o.col = 2'd1;
      end else if (c == 5'd11) begin
        cmd_o.row = 2'd3;
        cmd_o.col = 2'd0;
      end else if (c == 5'd12) begin
        cmd_o.row = 2'd3;
        cmd_o.col = 2'd2;
      end else begin
        cmd_o.row = 2'(c - 5'd13);
        cmd_o.col = 2'd3;
      end
    end else if (!c[3]) begin
      if (!c[2]) begin
        cmd_o.row_en = 1'b1;
        cmd_o.row    = c[1:0];
      end else begin
        cmd_o.col_en = 1'b1;
        cmd_o.col    = c[1:0];
      end
    end else if (c != 5'd31) begin
      valid_o = 1'b0;
    end
  end
endmodule

// File: rtl/dtmf_cmd_rx.sv
module dtmf_cmd_rx
  import dtmf_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAR_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic             mode_par_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic [PAR_W-1:0] pdata_i,
  output logic [1:0]       row_o,
  output logic [1:0]       col_o,
  output logic             row_en_o,
  output logic             col_en_o,
  output logic             cmd_valid_o
);
  localparam int SW = PAR_W + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b0, {PAR_W{1'b1}}};

  logic [SW-1:0]     sync_s;
  logic              cen_s, par_s, sclk_s, sdata_s;
  logic [PAR_W-1:0]  pdata_s;
  logic              sclk_q, fall, clr;
  logic [CODE_W-1:0] ser_word, code;
  logic              ser_done, take, dec_valid;
  logic [PAR_W-1:0]  pdata_q;
  logic              par_first_q, par_commit;
  tone_cmd_t         dec_cmd, cmd_q;

  dtmf_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cen_i, mode_par_i, sclk_i, sdata_i, pdata_i}),
    .q_o   (sync_s)
  );
  assign {cen_s, par_s, sclk_s, sdata_s, pdata_s} = sync_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_s;
  end

  assign clr  = cen_s | par_s;
  assign fall = sclk_q & ~sclk_s & ~clr;

  dtmf_ser_shift #(.CODE_W(CODE_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .fall_i(fall),
    .bit_i (sdata_s),
    .word_o(ser_word),
    .done_o(ser_done)
  );

  // parallel: take bus on mode entry and on every value change
  assign par_commit = par_s & ~cen_s & (par_first_q | (pdata_s != pdata_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_first_q <= 1'b1;
      pdata_q     <= '0;
    end else if (!par_s || cen_s) begin
      par_first_q <= 1'b1;
    end else if (par_commit) begin
      par_first_q <= 1'b0;
      pdata_q     <= pdata_s;
    end
  end

  assign code = par_commit ? CODE_W'(pdata_s) : ser_word;
  assign take = par_commit | ser_done;

  dtmf_decode u_dec (
    .code_i (code),
    .valid_o(dec_valid),
    .cmd_o  (dec_cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= TONE_OFF;
      cmd_valid_o <= 1'b0;
    end else if (cen_s) begin
      cmd_q       <= TONE_OFF;
      cmd_valid_o <= 1'b0;
    end else if (take && dec_valid) begin
      cmd_q       <= dec_cmd;
      cmd_valid_o <= 1'b1;
    end else begin
      cmd_valid_o <= 1'b0;
    end
  end

  assign row_en_o = cmd_q.row_en;
  assign col_en_o = cmd_q.col_en;
  assign row_o    = cmd_q.row;
  assign col_o    = cmd_q.col;

  p_idle_ce_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_s |=> (!row_en_o && !col_en_o && !cmd_valid_o));
  p_unused_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !dec_valid && !cen_s) |=> (!cmd_valid_o && $stable(cmd_q)));
  p_change_has_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q != $past(cmd_q)) |-> (cmd_valid_o || $past(cen_s)));
  p_par_dual_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && $past(par_s)) |-> (row_en_o && col_en_o));
endmodule

// File: tb/dtmf_cmd_rx_tb.sv
`timescale 1ns/1ps
module dtmf_cmd_rx_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cen = 1'b1, mode_par = 1'b0, sclk = 1'b1, sdata = 1'b0;
  logic [3:0] pdata = 4'hF;
  logic [1:0] row_o, col_o;
  logic       row_en_o, col_en_o, cmd_valid_o;
  int         n_chk = 0, n_fail = 0, pulses = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  dtmf_cmd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cen_i(cen), .mode_par_i(mode_par),
    .sclk_i(sclk), .sdata_i(sdata), .pdata_i(pdata),
    .row_o(row_o), .col_o(col_o), .row_en_o(row_en_o), .col_en_o(col_en_o),
    .cmd_valid_o(cmd_valid_o)
  );

  always @(negedge clk) if (cmd_valid_o) pulses++;

  // {valid, row_en, col_en, row, col}
  function automatic logic [6:0] ref_cmd(int c);
    int r, k;
    if (c < 16) begin
      if (c == 0)      begin r = 3; k = 3; end
      else if (c < 10) begin r = (c - 1) / 3; k = (c - 1) % 3; end
      else if (c == 10) begin r = 3; k = 1; end
      else if (c == 11) begin r = 3; k = 0; end
      else if (c == 12) begin r = 3; k = 2; end
      else             begin r = c - 13; k = 3; end
      return {3'b111, 2'(r), 2'(k)};
    end
    if (c < 20) return {3'b110, 2'(c - 16), 2'b00};
    if (c < 24) return {3'b101, 2'b00, 2'(c - 20)};
    if (c == 31) return 7'b1000000;
    return 7'b0;
  endfunction

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {row_en_o, col_en_o, row_o, col_o};
  endfunction

  task automatic send_bits(logic [4:0] code, int n);
    for (int i = 0; i < n; i++) begin
      sdata = code[i];
      wait_clks(4);
      sclk = 1'b0;
      wait_clks(6);
      sclk = 1'b1;
      wait_clks(4);
    end
    wait_clks(8);
  endtask

  initial begin
    logic [5:0] exp_st;
    int         p0;
    string      tag;
    wait_clks(3);
    rst_ni = 1'b1;
    wait_clks(6);
    check("R9 reset outputs", {outs(), cmd_valid_o}, 7'b0);

    cen = 1'b0;
    wait_clks(6);
    exp_st = 6'b0;
    // R1 R2 R3 R4 R5: full serial sweep
    for (int c = 0; c < 32; c++) begin
      logic [6:0] e;
      e   = ref_cmd(c);
      p0  = pulses;
      send_bits(5'(c), 5);
      if (e[6]) exp_st = e[5:0];
      tag = (c < 16) ? "R2" : (c < 24) ? "R3" : (c == 31) ? "R4" : "R5";
      check($sformatf("%s code %0d outputs", tag, c), outs(), exp_st);
      check($sformatf("R7 code %0d pulse count", c), pulses - p0, e[6] ? 1 : 0);
    end

    // R1: bit order, 6 and 12 are bit reverses of each other
    send_bits(5'd6, 5);
    check("R1 lsb-first code 6", outs(), ref_cmd(6) & 7'h3F);

    // R6: chip enable rises mid-word
    send_bits(5'd31, 3);
    cen = 1'b1;
    wait_clks(8);
    check("R6 outputs off under ce high", {outs(), cmd_valid_o}, 7'b0);
    p0 = pulses;
    send_bits(5'd9, 5);
    check("R6 clocks ignored under ce high", {pulses - p0, outs()}, 0);
    cen = 1'b0;
    wait_clks(6);
    send_bits(5'd5, 5);
    check("R6 partial word discarded", outs(), ref_cmd(5) & 7'h3F);

    // R8: parallel sweep
    pdata = 4'd0;
    wait_clks(4);
    p0 = pulses;
    mode_par = 1'b1;
    wait_clks(10);
    check("R8 entry commit code 0", outs(), ref_cmd(0) & 7'h3F);
    check("R8 entry pulse", pulses - p0, 1);
    for (int b = 1; b < 16; b++) begin
      p0 = pulses;
      pdata = 4'(b);
      wait_clks(10);
      check($sformatf("R8 bus %0d outputs", b), outs(), ref_cmd(b) & 7'h3F);
      check($sformatf("R7 bus %0d pulse", b), pulses - p0, 1);
    end
    p0 = pulses;
    wait_clks(20);
    send_bits(5'd3, 5);
    check("R8 stable bus and serial ignored", {pulses - p0, outs()},
          {32'd0, 6'(ref_cmd(15))});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule